// File: doc/BRIEF.md
# Preload Address Generation Unit

This block works out the byte address for a cache preload hint. The address comes from one of three operand forms. The first is a base value plus a signed immediate. The second is a base value plus or minus an index value that has passed through a full operand shifter. The third is the program counter plus a signed immediate. Each request gets one registered answer in the cycle that follows. The answer is either an address with a valid strobe or an illegal-operand flag.

Two instruction-set modes apply different legality rules. The wide mode allows the full shifter, subtraction, and immediates of ±4095. The compact mode allows only a left shift of up to 3 bits, only addition, and immediates from -255 to +4095. A configuration input can turn preload support off. When it is off, every request becomes a no-op.

Top module: `pagu_top`

## Requirements
- R1: In immediate form (form code 0) the result is the base plus the signed immediate, where the immediate is a 13-bit magnitude with a separate negative flag. A zero immediate gives back the base unchanged. The sum wraps modulo 2^32 and the wrap is not flagged.
- R2: The immediate limits are ±4095 in wide mode (mode 0) and -255..+4095 in compact mode (mode 1). An immediate outside the limit for the current mode raises illegal, gives no valid strobe, and leaves the address output unchanged.
- R3: In PC-relative form (form code 2) the result is the PC plus the signed immediate, and the R2 limits apply.
- R4: In register form (form code 1) the result is the base plus the shifted index, or the base minus it when the subtract selector is 1. A subtract request in compact mode is illegal.
- R5: In compact mode the only legal register-form shift is a left shift (type 0) of 0 to 3 bits. Any other type or amount is illegal.
- R6: The wide-mode shift type codes are 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR and 4 = RRX. The legal amounts are LSL 0..31, LSR 1..32, ASR 1..32 and ROR 1..31. RRX ignores the amount and yields {carry, index[31:1]}. Any other code or amount is illegal.
- R7: A logical right shift by 32 yields 0. An arithmetic right shift by 32 yields 32 copies of the index sign bit.
- R8: In register form an index register number of 15 is illegal. In the other forms this number is ignored. Form code 3 is always illegal.
- R9: No alignment check is made, so odd byte addresses are valid results.
- R10: While the enable input is low, a request produces neither valid nor illegal, and the address output holds.
- R11: The result appears in the cycle after the request strobe. A cycle without a request gives valid and illegal both low. A synchronous active-high reset clears the address, valid and illegal to 0.
- R12: Valid and illegal are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Preload support enabled |
| req_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 wide, 1 compact |
| form_i | input | 2 | 0 immediate, 1 register, 2 PC-relative |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| pc_i | input | 32 | Current PC |
| imm_i | input | 13 | Immediate magnitude |
| imm_neg_i | input | 1 | Immediate is negative |
| shtype_i | input | 3 | Shift type code |
| shamt_i | input | 6 | Shift amount 0..63 |
| sub_i | input | 1 | Subtract shifted index |
| carry_i | input | 1 | Carry flag for RRX |
| idx_reg_i | input | 4 | Index register number |
| addr_o | output | 32 | Registered preload address |
| valid_o | output | 1 | Address valid strobe |
| illegal_o | output | 1 | Illegal operand flag |

## Verification
A wrong shifter variant or a wrong legality decision shows up one cycle after the request. It appears as a wrong address, or as a valid strobe where an illegal flag was due, or the reverse. The corner cases include shift amounts of 32, RRX and both boundaries of each mode's immediate range. A damaged hold path shows a little later. It appears as an address that moves after an illegal or disabled request, and it is visible at the first sample after that request.

// File: rtl/pagu_pkg.sv
package pagu_pkg;
    typedef enum logic [0:0] {MODE_WIDE = 1'b0, MODE_COMPACT = 1'b1} mode_e;
    typedef enum logic [1:0] {FORM_IMM = 2'd0, FORM_REG = 2'd1, FORM_PCREL = 2'd2, FORM_RSVD = 2'd3} form_e;
    typedef enum logic [2:0] {SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3, SH_RRX = 3'd4} shift_e;
endpackage

// File: rtl/pagu_shifter.sv
module pagu_shifter #(
    parameter int DW  = 32,
    parameter int SHW = $clog2(DW) + 1
) (
    input  logic [DW-1:0]  val_i,
    input  logic [2:0]     type_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           carry_i,
    output logic [DW-1:0]  res_o
);
    import pagu_pkg::*;

    localparam logic [SHW-1:0] FULL = SHW'(DW);

    logic [SHW-2:0]  low_amt;
    logic [2*DW-1:0] rot_dbl;

    assign low_amt = amt_i[SHW-2:0];
    assign rot_dbl = {val_i, val_i} >> low_amt;

    always_comb begin
        res_o = val_i;
        unique case (shift_e'(type_i))
            SH_LSL: res_o = val_i << low_amt;
            SH_LSR: res_o = (amt_i == FULL) ? '0 : (val_i >> low_amt);
            SH_ASR: res_o = (amt_i == FULL) ? {DW{val_i[DW-1]}}
                                            : $unsigned($signed(val_i) >>> low_amt);
            SH_ROR: res_o = rot_dbl[DW-1:0];
            SH_RRX: res_o = {carry_i, val_i[DW-1:1]};
            default: res_o = val_i;
        endcase
    end
endmodule

// File: rtl/pagu_legal.sv
module pagu_legal #(
    parameter int DW              = 32,
    parameter int SHW             = $clog2(DW) + 1,
    parameter int IMMW            = 13,
    parameter int RIDXW           = 4,
    parameter int IMM_POS_MAX     = 4095,
    parameter int WIDE_NEG_MAX    = 4095,
    parameter int COMPACT_NEG_MAX = 255,
    parameter int COMPACT_LSL_MAX = 3,
    parameter int FORBID_RIDX     = 15
) (
    input  logic             mode_i,
    input  logic [1:0]       form_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic             imm_neg_i,
    input  logic [2:0]       shtype_i,
    input  logic [SHW-1:0]   shamt_i,
    input  logic             sub_i,
    input  logic [RIDXW-1:0] idx_reg_i,
    output logic             ok_o
);
    import pagu_pkg::*;

    localparam logic [IMMW-1:0]  POS_LIM  = IMMW'(IMM_POS_MAX);
    localparam logic [IMMW-1:0]  WNEG_LIM = IMMW'(WIDE_NEG_MAX);
    localparam logic [IMMW-1:0]  CNEG_LIM = IMMW'(COMPACT_NEG_MAX);
    localparam logic [SHW-1:0]   CLSL_LIM = SHW'(COMPACT_LSL_MAX);
    localparam logic [SHW-1:0]   FULL     = SHW'(DW);
    localparam logic [RIDXW-1:0] BAD_RIDX = RIDXW'(FORBID_RIDX);

    logic imm_ok, shift_ok, reg_ok;

    always_comb begin
        if (!imm_neg_i)
            imm_ok = (imm_i <= POS_LIM);
        else if (mode_e'(mode_i) == MODE_COMPACT)
            imm_ok = (imm_i <= CNEG_LIM);
        else
            imm_ok = (imm_i <= WNEG_LIM);
    end

    always_comb begin
        shift_ok = 1'b0;
        if (mode_e'(mode_i) == MODE_COMPACT) begin
            shift_ok = (shift_e'(shtype_i) == SH_LSL) && (shamt_i <= CLSL_LIM);
        end else begin
            case (shift_e'(shtype_i))
                SH_LSL: shift_ok = (shamt_i < FULL);
                SH_LSR,
                SH_ASR: shift_ok = (shamt_i != '0) && (shamt_i <= FULL);
                SH_ROR: shift_ok = (shamt_i != '0) && (shamt_i < FULL);
                SH_RRX: shift_ok = 1'b1;
                default: shift_ok = 1'b0;
            endcase
        end
    end

    assign reg_ok = shift_ok && (idx_reg_i != BAD_RIDX)
                    && !(sub_i && (mode_e'(mode_i) == MODE_COMPACT));

    always_comb begin
        case (form_e'(form_i))
            FORM_IMM,
            FORM_PCREL: ok_o = imm_ok;
            FORM_REG:   ok_o = reg_ok;
            default:    ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pagu_top.sv
module pagu_top #(
    parameter int DW    = 32,
    parameter int IMMW  = 13,
    parameter int RIDXW = 4,
    parameter int SHW   = $clog2(DW) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             req_i,
    input  logic             mode_i,
    input  logic [1:0]       form_i,
    input  logic [DW-1:0]    base_i,
    input  logic [DW-1:0]    index_i,
    input  logic [DW-1:0]    pc_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic             imm_neg_i,
    input  logic [2:0]       shtype_i,
    input  logic [SHW-1:0]   shamt_i,
    input  logic             sub_i,
    input  logic             carry_i,
    input  logic [RIDXW-1:0] idx_reg_i,
    output logic [DW-1:0]    addr_o,
    output logic             valid_o,
    output logic             illegal_o
);
    import pagu_pkg::*;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic          valid;
        logic          illegal;
    } out_t;

    out_t          st_d, st_q;
    logic [DW-1:0] shifted;
    logic          ok;
    logic [DW-1:0] imm_ext, imm_signed, target;

    pagu_shifter #(.DW(DW), .SHW(SHW)) u_shift (
        .val_i   (index_i),
        .type_i  (shtype_i),
        .amt_i   (shamt_i),
        .carry_i (carry_i),
        .res_o   (shifted)
    );

    pagu_legal #(.DW(DW), .SHW(SHW), .IMMW(IMMW), .RIDXW(RIDXW)) u_legal (
        .mode_i    (mode_i),
        .form_i    (form_i),
        .imm_i     (imm_i),
        .imm_neg_i (imm_neg_i),
        .shtype_i  (shtype_i),
        .shamt_i   (shamt_i),
        .sub_i     (sub_i),
        .idx_reg_i (idx_reg_i),
        .ok_o      (ok)
    );

    assign imm_ext    = {{(DW-IMMW){1'b0}}, imm_i};
    assign imm_signed = imm_neg_i ? (~imm_ext + 1'b1) : imm_ext;

    always_comb begin
        case (form_e'(form_i))
            FORM_REG:   target = sub_i ? (base_i - shifted) : (base_i + shifted);
            FORM_PCREL: target = pc_i + imm_signed;
            default:    target = base_i + imm_signed;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.illegal = 1'b0;
        if (req_i && en_i) begin
            st_d.valid   = ok;
            st_d.illegal = !ok;
            if (ok) st_d.addr = target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr_o    = st_q.addr;
    assign valid_o   = st_q.valid;
    assign illegal_o = st_q.illegal;
endmodule

// File: rtl/pagu_chk.sv
module pagu_chk #(
    parameter int DW    = 32,
    parameter int IMMW  = 13,
    parameter int RIDXW = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             req_i,
    input logic             mode_i,
    input logic [1:0]       form_i,
    input logic [DW-1:0]    base_i,
    input logic [IMMW-1:0]  imm_i,
    input logic             sub_i,
    input logic [RIDXW-1:0] idx_reg_i,
    input logic [DW-1:0]    addr_o,
    input logic             valid_o,
    input logic             illegal_o
);
    // R12
    excl_chk: assert property (@(posedge clk) disable iff (rst) !(valid_o && illegal_o));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!valid_o && !illegal_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!valid_o && !illegal_o));

    // R11
    answer_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && en_i) |=> (valid_o || illegal_o));

    // R2
    hold_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(addr_o));

    // R4
    compact_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && en_i && mode_i && form_i == 2'd1 && sub_i) |=> illegal_o);

    // R8
    ridx15_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && en_i && form_i == 2'd1 && idx_reg_i == RIDXW'(15)) |=> illegal_o);

    // R1
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && en_i && form_i == 2'd0 && imm_i == '0) |=> (valid_o && addr_o == $past(base_i)));
endmodule

bind pagu_top pagu_chk #(.DW(DW), .IMMW(IMMW), .RIDXW(RIDXW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .req_i     (req_i),
    .mode_i    (mode_i),
    .form_i    (form_i),
    .base_i    (base_i),
    .imm_i     (imm_i),
    .sub_i     (sub_i),
    .idx_reg_i (idx_reg_i),
    .addr_o    (addr_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
);

// File: tb/sim_pagu_top.sv
module sim_pagu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b1;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [1:0]  form_i = 2'd0;
    logic [31:0] base_i = '0, index_i = '0, pc_i = '0;
    logic [12:0] imm_i = '0;
    logic        imm_neg_i = 1'b0;
    logic [2:0]  shtype_i = '0;
    logic [5:0]  shamt_i = '0;
    logic        sub_i = 1'b0, carry_i = 1'b0;
    logic [3:0]  idx_reg_i = '0;
    logic [31:0] addr_o;
    logic        valid_o, illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pagu_top u0 (.*);

    typedef struct packed {
        logic        mode;
        logic [1:0]  form;
        logic [31:0] base;
        logic [31:0] index;
        logic [31:0] pc;
        logic        neg;
        logic [12:0] imm;
        logic [2:0]  sht;
        logic [5:0]  amt;
        logic        sub;
        logic        carry;
        logic [3:0]  ridx;
        logic        ev;
        logic        ei;
        logic [31:0] ea;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        // R1 plain add
        '{1'b0, 2'd0, 32'h1000, 32'h0, 32'h0, 1'b0, 13'd5, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'h1005},
        // R2 wide negative boundary
        '{1'b0, 2'd0, 32'h1000, 32'h0, 32'h0, 1'b1, 13'd4095, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'h1},
        // R2 wide negative out of range
        '{1'b0, 2'd0, 32'h1000, 32'h0, 32'h0, 1'b1, 13'd4096, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 32'h0},
        // R2 wide positive out of range
        '{1'b0, 2'd0, 32'h1000, 32'h0, 32'h0, 1'b0, 13'd4096, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 32'h0},
        // R2 compact negative boundary
        '{1'b1, 2'd0, 32'h100, 32'h0, 32'h0, 1'b1, 13'd255, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'h1},
        // R2 compact negative out of range
        '{1'b1, 2'd0, 32'h100, 32'h0, 32'h0, 1'b1, 13'd256, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 32'h0},
        // R2 compact positive boundary
        '{1'b1, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 13'd4095, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'hFFF},
        // R1 wraparound
        '{1'b0, 2'd0, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0, 13'd2, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'h1},
        // R1 R9 zero offset, odd address
        '{1'b0, 2'd0, 32'h12345677, 32'h0, 32'h0, 1'b0, 13'd0, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'h12345677},
        // R3 PC-relative negative
        '{1'b0, 2'd2, 32'h5555, 32'h0, 32'h8000, 1'b1, 13'd8, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 32'h7FF8},
        // R3 PC-relative compact out of range
        '{1'b1, 2'd2, 32'h0, 32'h0, 32'h8000, 1'b1, 13'd256, 3'd0, 6'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 32'h0},
        // R4 wide add LSL 2
        '{1'b0, 2'd1, 32'h100, 32'h10, 32'h0, 1'b0, 13'd0, 3'd0, 6'd2, 1'b0, 1'b0, 4'd1, 1'b1, 1'b0, 32'h140},
        // R4 wide subtract
        '{1'b0, 2'd1, 32'h100, 32'h10, 32'h0, 1'b0, 13'd0, 3'd0, 6'd0, 1'b1, 1'b0, 4'd1, 1'b1, 1'b0, 32'hF0},
        // R4 compact subtract illegal
        '{1'b1, 2'd1, 32'h100, 32'h10, 32'h0, 1'b0, 13'd0, 3'd0, 6'd0, 1'b1, 1'b0, 4'd1, 1'b0, 1'b1, 32'h0},
        // R5 compact LSL 3
        '{1'b1, 2'd1, 32'h0, 32'h1, 32'h0, 1'b0, 13'd0, 3'd0, 6'd3, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0, 32'h8},
        // R5 compact LSL 4 illegal
        '{1'b1, 2'd1, 32'h0, 32'h1, 32'h0, 1'b0, 13'd0, 3'd0, 6'd4, 1'b0, 1'b0, 4'd2, 1'b0, 1'b1, 32'h0},
        // R5 compact LSR illegal
        '{1'b1, 2'd1, 32'h0, 32'h1, 32'h0, 1'b0, 13'd0, 3'd1, 6'd1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b1, 32'h0},
        // R7 LSR 32
        '{1'b0, 2'd1, 32'h10, 32'hFFFFFFFF, 32'h0, 1'b0, 13'd0, 3'd1, 6'd32, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 32'h10},
        // R7 ASR 32 negative
        '{1'b0, 2'd1, 32'h0, 32'h80000000, 32'h0, 1'b0, 13'd0, 3'd2, 6'd32, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 32'hFFFFFFFF},
        // R7 ASR 32 positive
        '{1'b0, 2'd1, 32'h5, 32'h7FFFFFFF, 32'h0, 1'b0, 13'd0, 3'd2, 6'd32, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 32'h5},
        // R6 ASR 4
        '{1'b0, 2'd1, 32'h0, 32'h80000000, 32'h0, 1'b0, 13'd0, 3'd2, 6'd4, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 32'hF8000000},
        // R6 ROR 8
        '{1'b0, 2'd1, 32'h0, 32'h12345678, 32'h0, 1'b0, 13'd0, 3'd3, 6'd8, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 32'h78123456},
        // R6 RRX with carry, amount ignored
        '{1'b0, 2'd1, 32'h0, 32'h3, 32'h0, 1'b0, 13'd0, 3'd4, 6'd9, 1'b0, 1'b1, 4'd3, 1'b1, 1'b0, 32'h80000001},
        // R6 LSR 0 illegal
        '{1'b0, 2'd1, 32'h0, 32'h3, 32'h0, 1'b0, 13'd0, 3'd1, 6'd0, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1, 32'h0},
        // R6 ROR 32 illegal
        '{1'b0, 2'd1, 32'h0, 32'h3, 32'h0, 1'b0, 13'd0, 3'd3, 6'd32, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1, 32'h0},
        // R6 LSL 32 illegal
        '{1'b0, 2'd1, 32'h0, 32'h3, 32'h0, 1'b0, 13'd0, 3'd0, 6'd32, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1, 32'h0},
        // R6 type code 5 illegal
        '{1'b0, 2'd1, 32'h0, 32'h3, 32'h0, 1'b0, 13'd0, 3'd5, 6'd1, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1, 32'h0},
        // R8 register 15 in register form
        '{1'b0, 2'd1, 32'h0, 32'h3, 32'h0, 1'b0, 13'd0, 3'd0, 6'd1, 1'b0, 1'b0, 4'd15, 1'b0, 1'b1, 32'h0},
        // R8 register 15 ignored in immediate form
        '{1'b0, 2'd0, 32'h20, 32'h0, 32'h0, 1'b0, 13'd1, 3'd0, 6'd0, 1'b0, 1'b0, 4'd15, 1'b1, 1'b0, 32'h21}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        mode_i = v.mode; form_i = v.form; base_i = v.base; index_i = v.index;
        pc_i = v.pc; imm_neg_i = v.neg; imm_i = v.imm; shtype_i = v.sht;
        shamt_i = v.amt; sub_i = v.sub; carry_i = v.carry; idx_reg_i = v.ridx;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        load(v);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        check(valid_o == v.ev, {tag, " valid"}, 32'(valid_o), 32'(v.ev));
        check(illegal_o == v.ei, {tag, " illegal"}, 32'(illegal_o), 32'(v.ei));
        // R12
        check(!(valid_o && illegal_o), "R12 exclusive", {30'd0, valid_o, illegal_o}, 32'd0);
        if (v.ev) check(addr_o == v.ea, {tag, " addr"}, addr_o, v.ea);
    endtask

    initial begin
        vec_t good, bad;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(addr_o == 32'h0 && !valid_o && !illegal_o, "R11 reset state",
              {addr_o[29:0], valid_o, illegal_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i]);
            check_vec(VEC[i], $sformatf("vec %0d", i));
        end

        good = VEC[0];
        bad  = VEC[2];

        // R2 address holds after an illegal request
        issue(good);
        held = addr_o;
        issue(bad);
        check(illegal_o && addr_o == held, "R2 hold on illegal", addr_o, held);

        // R10 disabled: legal request ignored
        issue(VEC[7]);
        held = addr_o;
        en_i = 1'b0;
        issue(good);
        check(!valid_o && !illegal_o, "R10 disabled legal", {30'd0, valid_o, illegal_o}, 32'd0);
        check(addr_o == held, "R10 disabled addr", addr_o, held);
        // R10 disabled: illegal request gives no flag
        issue(bad);
        check(!valid_o && !illegal_o, "R10 disabled illegal", {30'd0, valid_o, illegal_o}, 32'd0);
        en_i = 1'b1;

        // R11 one-cycle strobe, idle afterwards
        issue(good);
        check(valid_o, "R11 strobe", 32'(valid_o), 32'd1);
        @(negedge clk);
        check(!valid_o && !illegal_o, "R11 idle", {30'd0, valid_o, illegal_o}, 32'd0);

        // R11 reset mid-run clears
        rst = 1'b1;
        @(negedge clk);
        check(addr_o == 32'h0 && !valid_o, "R11 sync reset", addr_o, 32'h0);
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule